// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 64 hardware interrupt lines and one software-raised interrupt, keeps per-source enable, pending, two-bit priority and trigger-mode state, and hands the processor core a single registered request together with the number of the winning source. Each line is first brought into the clock domain through a synchronizer. For each line, software picks whether it is captured on a rising edge or tracked as a level.

Software reaches the state through a word-addressed register port with separate read and write strobes. Hardware pending flags are cleared by writing ones. The software interrupt flag is written directly. A global enable input from the core gates the outgoing request. Vector fetch, nesting and the core's own interrupt state are handled elsewhere.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the request output is 0, the source number output is 0, and every mapped register reads 0. All sources start disabled, level-triggered and at priority 0.
- R2: The word addresses are: 0, 1 and 2 for the enable registers; 3, 4 and 5 for the pending registers; 6 to 9 for the priority registers; 10 and 11 for the trigger registers. Read data appears on the clock edge that samples the read strobe and holds until the next read. Enable register 0 holds sources 0–15 at bits 0–15 and the software interrupt enable at bit 16. Enable register 1 holds sources 16–31 at bits 16–31. Enable register 2 holds sources 32–63 at bit n−32. All other bits read 0.
- R3: Priority register k (address 6+k) holds sources 16k to 16k+15. Source n sits at bits [2j+1:2j], where j = n−16k. Every bit reads back as written.
- R4: When a source is edge-triggered, a rising input held for two or more cycles sets its pending bit on the third rising clock edge after the input rises. Pending registers 0, 1 and 2 show sources at the same bit positions as the enable registers. The bit stays set after the input falls. Writing 1 to the bit clears it. Writing 0 leaves it unchanged.
- R5: When a source is level-triggered, its pending bit follows the synchronized input. Writing 1 to the bit while the input stays high does not clear it.
- R6: Any write to address 3 loads bit 16 of the data into the software pending flag, which sets or clears it. No input line can change that flag.
- R7: Among the sources that are pending and enabled, the one with the smallest priority value wins. On equal priority, the lower source number wins. The software interrupt is chosen only when no hardware source qualifies.
- R8: On the clock edge after the state changes, the request output is set if any source is pending and enabled. The 7-bit source number output carries the winner, with 64 meaning the software interrupt. It is 0 while there is no request.
- R9: While the global enable input is low, the request output goes low on the next edge, and so does the source number.
- R10: A read of addresses 12 to 15 returns 0.
- R11: Trigger register 0 (address 10) holds sources 0–31 at bit n. Trigger register 1 (address 11) holds sources 32–63 at bit n−32. A value of 1 means edge-triggered and 0 means level-triggered.
- R12: A rising edge can set an edge-triggered pending bit in the same cycle that a write of 1 clears it. When that happens, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 64 | Asynchronous hardware interrupt lines |
| glb_en | input | 1 | Global enable that gates the request |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_id | output | 7 | Registered number of the winning source (64 = software) |

## Verification
Two functions can fall in the same cycle: a synchronized rising edge setting a pending bit, and a software write of 1 clearing that bit. The bench raises an edge-triggered line, then issues the clearing write on a sweep of clock edges before, at and after the edge on which detection sets the bit. For each offset it compares the read-back pending bit with the expected value: set when the clear lands on or before the set, cleared when it lands after. A second overlap is a level-triggered clear arriving while the line is still high. The bench judges that case by reading the bit back and by seeing the request stay up.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int unsigned NUM_HW_DEF  = 64;
   localparam int unsigned PRIO_W_DEF  = 2;
   localparam int unsigned DATA_W_DEF  = 32;
   localparam int unsigned ADDR_W_DEF  = 4;
   localparam int unsigned SYNC_N_DEF  = 2;

   localparam logic [3:0] A_EN0   = 4'd0;
   localparam logic [3:0] A_EN1   = 4'd1;
   localparam logic [3:0] A_EN2   = 4'd2;
   localparam logic [3:0] A_PND0  = 4'd3;
   localparam logic [3:0] A_PND1  = 4'd4;
   localparam logic [3:0] A_PND2  = 4'd5;
   localparam logic [3:0] A_PRI0  = 4'd6;
   localparam logic [3:0] A_TRG0  = 4'd10;
   localparam logic [3:0] A_TRG1  = 4'd11;

   localparam int unsigned SWI_BIT = 16;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_line_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else if (s == 0) chain_q[s] <= raw_in;
         else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
   import irq_prio_pkg::*;
#(
   parameter int unsigned NUM_HW = NUM_HW_DEF,
   parameter int unsigned PRIO_W = PRIO_W_DEF,
   parameter int unsigned DATA_W = DATA_W_DEF,
   parameter int unsigned ADDR_W = ADDR_W_DEF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_HW-1:0]        lvl_in,
   output logic [DATA_W-1:0]        rdata,
   output logic [NUM_HW-1:0]        en_hw,
   output logic                     en_swi,
   output logic [NUM_HW-1:0]        pnd_hw,
   output logic                     pnd_swi,
   output logic [NUM_HW*PRIO_W-1:0] prio,
   output logic [NUM_HW-1:0]        edge_mode,
   output logic [NUM_HW-1:0]        clr_vec
);
   localparam int unsigned HALF    = DATA_W / 2;
   localparam int unsigned PRI_PER = DATA_W / PRIO_W;
   localparam int unsigned PRI_REGS = NUM_HW / PRI_PER;

   logic [NUM_HW-1:0] prev_lvl_q;
   logic [NUM_HW-1:0] rise;
   logic [DATA_W-1:0] rmux;

   assign rise = lvl_in & ~prev_lvl_q;

   always_comb begin
      clr_vec = '0;
      if (wr_en) begin
         case (addr)
            A_PND0:  clr_vec[HALF-1:0]        = wdata[HALF-1:0];
            A_PND1:  clr_vec[DATA_W-1:HALF]   = wdata[DATA_W-1:HALF];
            A_PND2:  clr_vec[NUM_HW-1:DATA_W] = wdata;
            default: clr_vec = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_hw     <= '0;
         en_swi    <= 1'b0;
         pnd_swi   <= 1'b0;
         edge_mode <= '0;
      end else if (wr_en) begin
         case (addr)
            A_EN0: begin
               en_hw[HALF-1:0] <= wdata[HALF-1:0];
               en_swi          <= wdata[SWI_BIT];
            end
            A_EN1:  en_hw[DATA_W-1:HALF]     <= wdata[DATA_W-1:HALF];
            A_EN2:  en_hw[NUM_HW-1:DATA_W]   <= wdata;
            A_PND0: pnd_swi                  <= wdata[SWI_BIT];
            A_TRG0: edge_mode[DATA_W-1:0]    <= wdata;
            A_TRG1: edge_mode[NUM_HW-1:DATA_W] <= wdata;
            default: ;
         endcase
      end
   end

   for (genvar k = 0; k < PRI_REGS; k++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prio[k*DATA_W +: DATA_W] <= '0;
         else if (wr_en && addr == ADDR_W'(int'(A_PRI0) + k))
            prio[k*DATA_W +: DATA_W] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl_q <= '0;
         pnd_hw     <= '0;
      end else begin
         prev_lvl_q <= lvl_in;
         for (int n = 0; n < NUM_HW; n++) begin
            if (edge_mode[n]) pnd_hw[n] <= (pnd_hw[n] & ~clr_vec[n]) | rise[n];
            else              pnd_hw[n] <= lvl_in[n];
         end
      end
   end

   always_comb begin
      rmux = '0;
      case (addr)
         A_EN0:  rmux = {{(DATA_W-HALF-1){1'b0}}, en_swi, en_hw[HALF-1:0]};
         A_EN1:  rmux = {en_hw[DATA_W-1:HALF], {HALF{1'b0}}};
         A_EN2:  rmux = en_hw[NUM_HW-1:DATA_W];
         A_PND0: rmux = {{(DATA_W-HALF-1){1'b0}}, pnd_swi, pnd_hw[HALF-1:0]};
         A_PND1: rmux = {pnd_hw[DATA_W-1:HALF], {HALF{1'b0}}};
         A_PND2: rmux = pnd_hw[NUM_HW-1:DATA_W];
         A_TRG0: rmux = edge_mode[DATA_W-1:0];
         A_TRG1: rmux = edge_mode[NUM_HW-1:DATA_W];
         default: begin
            for (int k = 0; k < PRI_REGS; k++)
               if (addr == ADDR_W'(int'(A_PRI0) + k)) rmux = prio[k*DATA_W +: DATA_W];
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rmux;
   end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
   parameter int unsigned NUM_HW = 64,
   parameter int unsigned PRIO_W = 2,
   parameter int unsigned ID_W   = $clog2(NUM_HW + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_HW-1:0]        cand_hw,
   input  logic                     cand_swi,
   input  logic [NUM_HW*PRIO_W-1:0] prio,
   input  logic                     gate,
   output logic                     req,
   output logic [ID_W-1:0]          id
);
   logic              found;
   logic [PRIO_W-1:0] best_p;
   logic [ID_W-1:0]   best_i;
   logic              any;
   logic [ID_W-1:0]   nxt_id;

   always_comb begin
      found  = 1'b0;
      best_p = '0;
      best_i = '0;
      for (int i = 0; i < NUM_HW; i++) begin
         if (cand_hw[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best_p)) begin
            found  = 1'b1;
            best_p = prio[i*PRIO_W +: PRIO_W];
            best_i = ID_W'(i);
         end
      end
      any    = found | cand_swi;
      nxt_id = found ? best_i : (cand_swi ? ID_W'(NUM_HW) : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
         id  <= '0;
      end else begin
         req <= gate & any;
         id  <= (gate & any) ? nxt_id : '0;
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int unsigned NUM_HW = NUM_HW_DEF,
   parameter int unsigned PRIO_W = PRIO_W_DEF,
   parameter int unsigned DATA_W = DATA_W_DEF,
   parameter int unsigned ADDR_W = ADDR_W_DEF,
   parameter int unsigned SYNC_N = SYNC_N_DEF,
   localparam int unsigned ID_W  = $clog2(NUM_HW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_HW-1:0] irq_in,
   input  logic              glb_en,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_req,
   output logic [ID_W-1:0]   irq_id
);
   if (NUM_HW != 2 * DATA_W) begin : g_bad_count
      $error("irq_prio_ctrl: register map needs NUM_HW == 2*DATA_W");
   end
   if (PRIO_W * (NUM_HW / (DATA_W / PRIO_W)) * (DATA_W / PRIO_W) != NUM_HW * PRIO_W) begin : g_bad_prio
      $error("irq_prio_ctrl: priority fields must tile the priority registers");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("irq_prio_ctrl: ADDR_W must cover 12 registers");
   end

   logic [NUM_HW-1:0]        lvl_sync;
   logic [NUM_HW-1:0]        en_hw;
   logic                     en_swi;
   logic [NUM_HW-1:0]        pnd_hw;
   logic                     pnd_swi;
   logic [NUM_HW*PRIO_W-1:0] prio;
   logic [NUM_HW-1:0]        edge_mode;
   logic [NUM_HW-1:0]        clr_vec;

   irq_line_sync #(.WIDTH(NUM_HW), .STAGES(SYNC_N)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (irq_in),
      .sync_out (lvl_sync)
   );

   irq_state_regs #(.NUM_HW(NUM_HW), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .rd_en     (reg_rd),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .lvl_in    (lvl_sync),
      .rdata     (reg_rdata),
      .en_hw     (en_hw),
      .en_swi    (en_swi),
      .pnd_hw    (pnd_hw),
      .pnd_swi   (pnd_swi),
      .prio      (prio),
      .edge_mode (edge_mode),
      .clr_vec   (clr_vec)
   );

   irq_prio_arbiter #(.NUM_HW(NUM_HW), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand_hw  (pnd_hw & en_hw),
      .cand_swi (pnd_swi & en_swi),
      .prio     (prio),
      .gate     (glb_en),
      .req      (irq_req),
      .id       (irq_id)
   );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int unsigned NUM_HW = 64,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned ID_W   = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              glb_en,
   input logic              irq_req,
   input logic [ID_W-1:0]   irq_id,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [NUM_HW-1:0] pnd_hw,
   input logic              pnd_swi,
   input logic [NUM_HW-1:0] lvl_sync,
   input logic [NUM_HW-1:0] edge_mode,
   input logic [NUM_HW-1:0] clr_vec
);
   a_r9_gate_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> (!irq_req && irq_id == '0));

   a_r8_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_id <= ID_W'(NUM_HW)));

   a_r6_swi_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(3)) |=> (pnd_swi == $past(reg_wdata[16])));

   a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ((pnd_hw ^ $past(lvl_sync)) & ~$past(edge_mode)) == '0);

   a_r4_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pnd_hw & edge_mode & ~clr_vec) & edge_mode) & ~pnd_hw) == '0);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_HW(NUM_HW), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .glb_en    (glb_en),
   .irq_req   (irq_req),
   .irq_id    (irq_id),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .pnd_hw    (pnd_hw),
   .pnd_swi   (pnd_swi),
   .lvl_sync  (lvl_sync),
   .edge_mode (edge_mode),
   .clr_vec   (clr_vec)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_in = '0;
   logic        glb_en = 1'b1;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_req;
   logic [6:0]  irq_id;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   irq_prio_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .glb_en(glb_en),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .irq_id(irq_id)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(posedge clk); @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] prio_w [4];
      logic [63:0] msk, lines;
      logic        swi_p, swi_e;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state, R10 unmapped addresses
      chk(irq_req == 1'b0 && irq_id == 7'd0, "R1 outputs after reset", {irq_req, irq_id}, 0);
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), v);
         chk(v == 32'd0, (a >= 12) ? "R10 unmapped read" : "R1 register after reset", v, 0);
      end

      // R2, R3, R11 read-back layout
      wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF); wr(4'd2, 32'hFFFF_FFFF);
      rd(4'd0, v); chk(v == 32'h0001_FFFF, "R2 enable reg 0 layout", v, 32'h0001_FFFF);
      rd(4'd1, v); chk(v == 32'hFFFF_0000, "R2 enable reg 1 layout", v, 32'hFFFF_0000);
      rd(4'd2, v); chk(v == 32'hFFFF_FFFF, "R2 enable reg 2 layout", v, 32'hFFFF_FFFF);
      for (int k = 0; k < 4; k++) begin
         wr(4'(6 + k), 32'h1234_5678 ^ (32'h1111_1111 * k));
      end
      for (int k = 0; k < 4; k++) begin
         rd(4'(6 + k), v);
         chk(v == (32'h1234_5678 ^ (32'h1111_1111 * k)), "R3 priority read-back", v,
             32'h1234_5678 ^ (32'h1111_1111 * k));
      end
      wr(4'd10, 32'hA5A5_0F0F); wr(4'd11, 32'h5A5A_F0F0);
      rd(4'd10, v); chk(v == 32'hA5A5_0F0F, "R11 trigger reg 0", v, 32'hA5A5_0F0F);
      rd(4'd11, v); chk(v == 32'h5A5A_F0F0, "R11 trigger reg 1", v, 32'h5A5A_F0F0);
      wr(4'd10, 32'd0); wr(4'd11, 32'd0);
      for (int k = 0; k < 4; k++) wr(4'(6 + k), 32'd0);

      // R5/R8 level sweep over every source
      for (int n = 0; n < 64; n++) begin
         logic [3:0] pa;
         int         pb;
         pa = (n < 16) ? 4'd3 : (n < 32) ? 4'd4 : 4'd5;
         pb = (n < 32) ? n : n - 32;
         irq_in = 64'd1 << n;
         idle(5);
         chk(irq_req && irq_id == 7'(n), "R8 single level source id", irq_id, n);
         wr(pa, 32'd1 << pb);
         rd(pa, v);
         chk(v[pb] == 1'b1, "R5 level clear has no lasting effect", v[pb], 1);
         if (n == 5) begin
            glb_en = 1'b0; idle(2);
            chk(!irq_req && irq_id == 7'd0, "R9 gate low drops request", irq_req, 0);
            glb_en = 1'b1; idle(2);
            chk(irq_req && irq_id == 7'd5, "R9 gate high restores request", irq_id, 5);
         end
         irq_in = '0;
         idle(5);
         chk(!irq_req, "R5 level release clears request", irq_req, 0);
      end

      // R7/R8 arbitration with computed winners
      for (int t = 0; t < 60; t++) begin
         int   exp_id;
         int   bp;
         bit   hit;
         for (int k = 0; k < 4; k++) prio_w[k] = $urandom;
         msk   = {$urandom, $urandom};
         lines = (t % 8 == 0) ? 64'd0 : ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
         swi_p = (t % 3 == 0);
         swi_e = (t % 2 == 0);
         wr(4'd0, {15'd0, swi_e, msk[15:0]});
         wr(4'd1, {msk[31:16], 16'd0});
         wr(4'd2, msk[63:32]);
         for (int k = 0; k < 4; k++) wr(4'(6 + k), prio_w[k]);
         wr(4'd3, {15'd0, swi_p, 16'd0});
         irq_in = lines;
         idle(5);
         hit = 1'b0; bp = 0; exp_id = 0;
         for (int i = 0; i < 64; i++) begin
            int p;
            p = (prio_w[i / 16] >> (2 * (i % 16))) & 3;
            if (lines[i] && msk[i] && (!hit || p < bp)) begin
               hit = 1'b1; bp = p; exp_id = i;
            end
         end
         if (!hit && swi_p && swi_e) exp_id = 64;
         chk(irq_req == (hit || (swi_p && swi_e)), "R7 request presence", irq_req, hit || (swi_p && swi_e));
         chk(irq_id == 7'(exp_id), "R7 winner by priority then number", irq_id, exp_id);
      end
      irq_in = '0;
      for (int k = 0; k < 4; k++) wr(4'(6 + k), 32'd0);

      // R6 software interrupt
      wr(4'd0, 32'h0001_0000); wr(4'd1, 32'd0); wr(4'd2, 32'd0);
      wr(4'd3, 32'h0001_0000); idle(2);
      chk(irq_req && irq_id == 7'd64, "R6 software interrupt id", irq_id, 64);
      rd(4'd3, v); chk(v == 32'h0001_0000, "R6 software pending read", v, 32'h0001_0000);
      irq_in = 64'h0001_0000_0000_0001; idle(5);
      wr(4'd3, 32'h0000_0000); idle(2);
      chk(!irq_req, "R6 software flag cleared, lines cannot raise it", irq_req, 0);
      irq_in = '0; idle(5);

      // R4 edge capture and write-one-to-clear
      wr(4'd10, 32'hFFFF_FFFF); wr(4'd11, 32'hFFFF_FFFF);
      wr(4'd2, 32'hFFFF_FFFF);
      irq_in[40] = 1'b1; idle(3); irq_in[40] = 1'b0; idle(6);
      chk(irq_req && irq_id == 7'd40, "R4 edge latched after input falls", irq_id, 40);
      wr(4'd5, 32'd0); rd(4'd5, v);
      chk(v == 32'h0000_0100, "R4 writing zero keeps pending", v, 32'h0000_0100);
      wr(4'd5, 32'h0000_0100); rd(4'd5, v);
      chk(v == 32'd0, "R4 write one clears edge pending", v, 0);
      idle(1);
      chk(!irq_req, "R4 request gone after clear", irq_req, 0);

      // R12 set/clear coincidence sweep on source 0
      wr(4'd0, 32'h0000_0001);
      for (int d = 0; d < 6; d++) begin
         irq_in[0] = 1'b0; idle(6);
         wr(4'd3, 32'h0000_0001);
         irq_in[0] = 1'b1;
         idle(d);
         wr(4'd3, 32'h0000_0001);
         irq_in[0] = 1'b0; idle(4);
         rd(4'd3, v);
         chk(v[0] == (d <= 2), "R12 clear vs edge set ordering", v[0], d <= 2);
      end

      done = 1'b1;
      finish_run();
   end
endmodule